// File: doc/BRIEF.md
# Bus Traffic Performance Counter Unit

This block watches one bus port and counts data beats on it. It has a free-running cycle counter and four event counters. Software programs each event counter to count read data beats, write data beats, or both. To measure load, software starts all counters together, stops them with one write, and then reads a snapshot of elapsed cycles against counted beats.

Software reaches the unit through a 32-bit register port with a valid/ready write channel and a valid/ready read channel. Read data comes back one cycle after the request. Each counter has its own enable bit. Enables are changed through a write-one-to-set register and a write-one-to-clear register. A global control register holds a run bit, two self-clearing reset bits and a start-mode field. Sticky overflow flags record every counter wrap. The last event counter is wider than the others and is read as a low word plus a high word.

Top module: `bus_perf_mon`

## Requirements
- R1: The cycle counter (CNT_W bits, address 0x40) adds one on every clock edge where the global run bit (control bit 0) is 1, the start mode is manual, and its enable bit (bit 31 of the enable state) is set.
- R2: A write to 0x10 ORs the written mask into the enable state, and a write to 0x20 clears the bits of the state that are set in the mask. Bits 0..3 enable event counters 0..3 and bit 31 enables the cycle counter. All other written bits are ignored. Both addresses read back the current enable state.
- R3: In a control write, bit 1 zeroes the event counters and bit 2 zeroes the cycle counter. The zero is visible from the next cycle and takes priority over an increment on the same edge. Both bits read back as 0.
- R4: Event type register i (0x60 + 4*i) selects the beats counter i counts. Bit 0 selects read beats (obs_rd_valid and obs_rd_ready both high). Bit 1 selects write beats (obs_wr_valid and obs_wr_ready both high). With both bits set and both beats in the same cycle, the counter adds 2. With neither bit set, the counter does not count.
- R5: While the global run bit is 0, every counter holds its value whatever the bus does.
- R6: Event counters 0..2 are CNT_W bits wide, at 0x44, 0x48 and 0x4C. Counter 3 is WIDE_W bits wide. Its lower CNT_W bits read at 0x50 and the bits above them read, right-aligned, at 0x54.
- R7: A counter that passes its maximum value continues from zero and sets its overflow flag at 0x30 (bit i for event counter i, bit 31 for the cycle counter). A flag stays set until a 1 is written to its bit at 0x30. A wrap on the same edge as that write wins.
- R8: Control bits 5:4 hold the start mode and read back as written. Only value 0 (manual) lets counters run. Any other value holds them.
- R9: A read request is answered on the next cycle by rd_resp_valid together with the data. Unmapped addresses read as zero. wr_ready and rd_ready are always high.
- R10: After reset, every register and counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Register read request |
| rd_ready | output | 1 | Read accepted (always high) |
| rd_addr | input | 8 | Read byte address |
| rd_resp_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| obs_rd_valid | input | 1 | Observed read-data valid |
| obs_rd_ready | input | 1 | Observed read-data ready |
| obs_wr_valid | input | 1 | Observed write-data valid |
| obs_wr_ready | input | 1 | Observed write-data ready |

## Verification
The bench sweeps the event-type encodings against beat patterns where valid is high but ready is low. A design that counts valid alone, or that adds 1 instead of 2 when both directions fire, shows a wrong total. It checks that the run bit is cleared on a counting edge and that counters then stay frozen while beats continue; an off-by-one in stop timing or a counter that ignores the run bit shows up there. It drives narrow counters past their wrap with 2-per-cycle steps. A design that saturates, drops the sticky flag, clears the wrong flag bit, or puts the wide counter's upper bits at the wrong place in the high word reads back wrong values. It also applies each reset bit alone, to catch a reset that zeroes the wrong group.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int NUM_EVT = 4;
  localparam int DATA_W  = 32;

  typedef logic [7:0]        addr_t;
  typedef logic [DATA_W-1:0] word_t;

  // register addresses
  localparam addr_t A_CTRL    = 8'h00;
  localparam addr_t A_EN_SET  = 8'h10;
  localparam addr_t A_EN_CLR  = 8'h20;
  localparam addr_t A_OVF     = 8'h30;
  localparam addr_t A_CYC     = 8'h40;
  localparam addr_t A_CNT0    = 8'h44;
  localparam addr_t A_CNT3_LO = 8'h50;
  localparam addr_t A_CNT3_HI = 8'h54;
  localparam addr_t A_EVT0    = 8'h60;

  // control bits
  localparam int B_RUN    = 0;
  localparam int B_EVRST  = 1;
  localparam int B_CYRST  = 2;
  localparam int B_MODE   = 4;
  localparam int B_CYC    = 31;

  // event select bits
  localparam int SEL_RD = 0;
  localparam int SEL_WR = 1;

  typedef enum logic [1:0] {
    MODE_MANUAL = 2'd0,
    MODE_RSV1   = 2'd1,
    MODE_RSV2   = 2'd2,
    MODE_RSV3   = 2'd3
  } mode_e;

  // internal mask: bits 0..NUM_EVT-1 events, bit NUM_EVT cycle counter
  function automatic word_t mask_to_word(input logic [NUM_EVT:0] m);
    word_t w;
    w = '0;
    w[NUM_EVT-1:0] = m[NUM_EVT-1:0];
    w[B_CYC]       = m[NUM_EVT];
    return w;
  endfunction

  function automatic logic [NUM_EVT:0] word_to_mask(input word_t w);
    return {w[B_CYC], w[NUM_EVT-1:0]};
  endfunction

  localparam word_t EN_MASK_W = mask_to_word({(NUM_EVT+1){1'b1}});
endpackage

// File: rtl/bpm_counter.sv
module bpm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic [1:0]   inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] sum;

  assign sum  = {1'b0, cnt} + {{(W-1){1'b0}}, inc};
  assign wrap = run && !clr && sum[W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= sum[W-1:0];
    end
  end
endmodule

// File: rtl/bpm_ctrl_regs.sv
module bpm_ctrl_regs
  import bpm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  addr_t                   wr_addr,
  input  word_t                   wr_data,
  output logic                    glb_en,
  output mode_e                   mode,
  output logic [NUM_EVT:0]        cnt_en,
  output logic [NUM_EVT-1:0][1:0] ev_sel,
  output logic                    evt_clr,
  output logic                    cyc_clr
);
  logic wr_ctrl, wr_set, wr_clr;
  logic [NUM_EVT:0] wmask;
  logic unused_wr_bits;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_set  = wr_en && (wr_addr == A_EN_SET);
  assign wr_clr  = wr_en && (wr_addr == A_EN_CLR);
  assign wmask   = word_to_mask(wr_data);

  // reset bits act as one-cycle pulses and are never stored
  assign evt_clr = wr_ctrl && wr_data[B_EVRST];
  assign cyc_clr = wr_ctrl && wr_data[B_CYRST];

  assign unused_wr_bits = ^{wr_data[DATA_W-1:B_MODE+2], wr_data[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en <= 1'b0;
      mode   <= MODE_MANUAL;
      cnt_en <= '0;
    end else begin
      if (wr_ctrl) begin
        glb_en <= wr_data[B_RUN];
        mode   <= mode_e'(wr_data[B_MODE +: 2]);
      end
      if (wr_set) cnt_en <= cnt_en | wmask;
      if (wr_clr) cnt_en <= cnt_en & ~wmask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_sel <= '0;
    end else begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (wr_en && (wr_addr == A_EVT0 + addr_t'(4*i))) begin
          ev_sel[i] <= wr_data[1:0];
        end
      end
    end
  end
endmodule

// File: rtl/bpm_rd_port.sv
module bpm_rd_port
  import bpm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 40
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_valid,
  input  addr_t                       rd_addr,
  input  logic                        glb_en,
  input  mode_e                       mode,
  input  logic [NUM_EVT:0]            cnt_en,
  input  logic [NUM_EVT:0]            ovf,
  input  logic [NUM_EVT-1:0][1:0]     ev_sel,
  input  logic [CNT_W-1:0]            cyc_cnt,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] ev_lo,
  input  logic [WIDE_W-1:0]           ev_wide,
  output logic                        rd_resp_valid,
  output word_t                       rd_data
);
  localparam int HI_W = WIDE_W - CNT_W;

  word_t nxt;

  always_comb begin
    nxt = '0;
    case (rd_addr)
      A_CTRL: begin
        nxt[B_RUN]       = glb_en;
        nxt[B_MODE +: 2] = mode;
      end
      A_EN_SET, A_EN_CLR: nxt = mask_to_word(cnt_en);
      A_OVF:              nxt = mask_to_word(ovf);
      A_CYC:              nxt[CNT_W-1:0] = cyc_cnt;
      A_CNT3_LO:          nxt[CNT_W-1:0] = ev_wide[CNT_W-1:0];
      A_CNT3_HI:          nxt[HI_W-1:0]  = ev_wide[WIDE_W-1:CNT_W];
      default: ;
    endcase
    for (int i = 0; i < NUM_EVT-1; i++) begin
      if (rd_addr == A_CNT0 + addr_t'(4*i)) nxt[CNT_W-1:0] = ev_lo[i];
    end
    for (int i = 0; i < NUM_EVT; i++) begin
      if (rd_addr == A_EVT0 + addr_t'(4*i)) nxt[1:0] = ev_sel[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_resp_valid <= 1'b0;
      rd_data       <= '0;
    end else begin
      rd_resp_valid <= rd_valid;
      if (rd_valid) rd_data <= nxt;
    end
  end
endmodule

// File: rtl/bus_perf_mon.sv
module bus_perf_mon
  import bpm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int WIDE_W = 40
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [7:0]  rd_addr,
  output logic        rd_resp_valid,
  output logic [31:0] rd_data,
  input  logic        obs_rd_valid,
  input  logic        obs_rd_ready,
  input  logic        obs_wr_valid,
  input  logic        obs_wr_ready
);
  logic                          glb_en;
  mode_e                         mode;
  logic [NUM_EVT:0]              cnt_en;
  logic [NUM_EVT-1:0][1:0]       ev_sel;
  logic                          evt_clr, cyc_clr;
  logic                          rbeat, wbeat, run_ok;
  logic [CNT_W-1:0]              cyc_cnt;
  logic [NUM_EVT-1:0][CNT_W-1:0] ev_lo;
  logic [WIDE_W-1:0]             ev_wide;
  logic [NUM_EVT:0]              wrap;
  logic [NUM_EVT:0]              ovf;
  logic [NUM_EVT:0]              ovf_clr_m;
  word_t                         en_word_s, ovf_word_s;

  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;

  assign rbeat  = obs_rd_valid && obs_rd_ready;
  assign wbeat  = obs_wr_valid && obs_wr_ready;
  assign run_ok = glb_en && (mode == MODE_MANUAL);

  bpm_ctrl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .glb_en  (glb_en),
    .mode    (mode),
    .cnt_en  (cnt_en),
    .ev_sel  (ev_sel),
    .evt_clr (evt_clr),
    .cyc_clr (cyc_clr)
  );

  bpm_counter #(.W(CNT_W)) u_cyc (
    .clk  (clk),
    .rst  (rst),
    .clr  (cyc_clr),
    .run  (run_ok && cnt_en[NUM_EVT]),
    .inc  (2'd1),
    .cnt  (cyc_cnt),
    .wrap (wrap[NUM_EVT])
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic [1:0] inc;
    assign inc = 2'(ev_sel[g][SEL_RD] & rbeat) + 2'(ev_sel[g][SEL_WR] & wbeat);
    if (g == NUM_EVT-1) begin : g_wide
      bpm_counter #(.W(WIDE_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (evt_clr),
        .run  (run_ok && cnt_en[g]),
        .inc  (inc),
        .cnt  (ev_wide),
        .wrap (wrap[g])
      );
      assign ev_lo[g] = ev_wide[CNT_W-1:0];
    end else begin : g_narrow
      bpm_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (evt_clr),
        .run  (run_ok && cnt_en[g]),
        .inc  (inc),
        .cnt  (ev_lo[g]),
        .wrap (wrap[g])
      );
    end
  end

  // sticky overflow flags, write-one-to-clear; a new wrap wins
  assign ovf_clr_m = (wr_valid && (wr_addr == A_OVF)) ? word_to_mask(wr_data) : '0;

  always_ff @(posedge clk) begin
    if (rst) ovf <= '0;
    else     ovf <= (ovf & ~ovf_clr_m) | wrap;
  end

  assign en_word_s  = mask_to_word(cnt_en);
  assign ovf_word_s = mask_to_word(ovf);

  bpm_rd_port #(.CNT_W(CNT_W), .WIDE_W(WIDE_W)) u_rd (
    .clk           (clk),
    .rst           (rst),
    .rd_valid      (rd_valid),
    .rd_addr       (rd_addr),
    .glb_en        (glb_en),
    .mode          (mode),
    .cnt_en        (cnt_en),
    .ovf           (ovf),
    .ev_sel        (ev_sel),
    .cyc_cnt       (cyc_cnt),
    .ev_lo         (ev_lo),
    .ev_wide       (ev_wide),
    .rd_resp_valid (rd_resp_valid),
    .rd_data       (rd_data)
  );
endmodule

// File: rtl/bpm_checker.sv
module bpm_checker
  import bpm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic [7:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic             rd_valid,
  input logic             rd_resp_valid,
  input logic             glb_en,
  input logic [31:0]      en_w,
  input logic [31:0]      ovf_w,
  input logic [CNT_W-1:0] cyc_cnt
);
  p_resp_next_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_resp_valid);

  p_resp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !rd_resp_valid);

  p_en_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == A_EN_SET) |=>
      ((en_w & $past(wr_data) & EN_MASK_W) == ($past(wr_data) & EN_MASK_W)));

  p_en_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == A_EN_CLR) |=> ((en_w & $past(wr_data) & EN_MASK_W) == '0));

  p_cyc_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == A_CTRL && wr_data[B_CYRST]) |=> (cyc_cnt == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!glb_en && !(wr_valid && wr_addr == A_CTRL)) |=> $stable(cyc_cnt));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_w[B_CYC] && !(wr_valid && wr_addr == A_OVF && wr_data[B_CYC])) |=> ovf_w[B_CYC]);
endmodule

bind bus_perf_mon bpm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_valid      (wr_valid),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .rd_valid      (rd_valid),
  .rd_resp_valid (rd_resp_valid),
  .glb_en        (glb_en),
  .en_w          (en_word_s),
  .ovf_w         (ovf_word_s),
  .cyc_cnt       (cyc_cnt)
);

// File: tb/bus_perf_mon_tb.sv
module bus_perf_mon_tb;
  localparam int CW = 8;
  localparam int WW = 12;

  localparam logic [7:0] T_CTRL = 8'h00, T_SET = 8'h10, T_CLR = 8'h20, T_OVF = 8'h30;
  localparam logic [7:0] T_CYC = 8'h40, T_C0 = 8'h44, T_C1 = 8'h48, T_C2 = 8'h4C;
  localparam logic [7:0] T_C3L = 8'h50, T_C3H = 8'h54, T_E0 = 8'h60, T_E1 = 8'h64;
  localparam logic [7:0] T_E2 = 8'h68, T_E3 = 8'h6C;

  // {event type[1:0], {rv,rr,wv,wr}, cycles[7:0]}
  localparam logic [13:0] VEC [7] = '{
    {2'd1, 4'b1100, 8'd20},
    {2'd2, 4'b1100, 8'd20},
    {2'd2, 4'b0011, 8'd30},
    {2'd3, 4'b1111, 8'd40},
    {2'd3, 4'b1011, 8'd25},
    {2'd1, 4'b1111, 8'd100},
    {2'd0, 4'b1111, 8'd10}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0, rd_valid = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic rv = 1'b0, rr = 1'b0, wv = 1'b0, wr = 1'b0;
  logic wr_ready, rd_ready, rd_resp_valid;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] v;
  logic resp;

  always #5 clk = ~clk;

  bus_perf_mon #(.CNT_W(CW), .WIDE_W(WW)) u_dut (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_data(rd_data),
    .obs_rd_valid(rv), .obs_rd_ready(rr), .obs_wr_valid(wv), .obs_wr_ready(wr)
  );

  // all tasks are entered at a falling edge
  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data; resp = rd_resp_valid;
    rd_valid = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [3:0] p);
    {rv, rr, wv, wr} = p;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    reg_rd(T_CTRL, v); chk("R10 ctrl", v, 0);
    chk("R9 resp valid", {31'd0, resp}, 1);
    reg_rd(T_SET, v);  chk("R10 enables", v, 0);
    reg_rd(T_OVF, v);  chk("R10 ovf", v, 0);
    reg_rd(T_CYC, v);  chk("R10 cycle", v, 0);
    reg_rd(T_C0, v);   chk("R10 cnt0", v, 0);
    reg_rd(T_C3H, v);  chk("R10 cnt3 hi", v, 0);
    reg_rd(T_E0, v);   chk("R10 evt0", v, 0);

    // R4 / R1 vector table on counter 0
    for (int i = 0; i < 7; i++) begin
      logic [1:0] et;
      logic [3:0] pat;
      int n, per;
      et = VEC[i][13:12]; pat = VEC[i][11:8]; n = int'(VEC[i][7:0]);
      per = int'(et[0] & pat[3] & pat[2]) + int'(et[1] & pat[1] & pat[0]);
      reg_wr(T_CLR, 32'hFFFF_FFFF);
      reg_wr(T_SET, 32'h8000_0001);
      reg_wr(T_E0, {30'd0, et});
      bus(4'b0000);
      reg_wr(T_CTRL, 32'h7);
      bus(pat);
      repeat (n) @(negedge clk);
      bus(4'b0000);
      reg_wr(T_CTRL, 32'h0);
      reg_rd(T_C0, v); chk("R4 event count", v, 32'(n * per));
      reg_rd(T_CYC, v); chk("R1 cycle count", v, 32'(n + 1));
    end

    // R5 hold while stopped
    reg_wr(T_E0, 32'h1);
    reg_wr(T_CTRL, 32'h7);
    bus(4'b1100);
    repeat (10) @(negedge clk);
    reg_wr(T_CTRL, 32'h0);
    repeat (20) @(negedge clk);
    reg_rd(T_C0, v);  chk("R5 cnt0 held", v, 11);
    reg_rd(T_CYC, v); chk("R5 cycle held", v, 11);

    // R8 non-manual mode holds counters, field reads back
    reg_wr(T_CTRL, 32'h6);
    reg_wr(T_CTRL, 32'h11);
    repeat (10) @(negedge clk);
    reg_rd(T_CTRL, v); chk("R8 mode readback", v, 32'h11);
    reg_wr(T_CTRL, 32'h0);
    reg_rd(T_CYC, v); chk("R8 cycle held", v, 0);
    reg_rd(T_C0, v);  chk("R8 cnt0 held", v, 0);

    // R3 reset bits self-clear and act separately
    reg_wr(T_CTRL, 32'h7);
    reg_rd(T_CTRL, v); chk("R3 reset bits read 0", v, 1);
    reg_wr(T_CTRL, 32'h0);
    reg_wr(T_CTRL, 32'h2);
    reg_rd(T_C0, v);  chk("R3 event reset", v, 0);
    reg_rd(T_CYC, v); chk("R3 cycle kept", v, 2);
    reg_wr(T_CTRL, 32'h4);
    reg_rd(T_CYC, v); chk("R3 cycle reset", v, 0);

    // R6 / R7 wrap and wide counter
    bus(4'b0000);
    reg_wr(T_CLR, 32'hFFFF_FFFF);
    reg_wr(T_SET, 32'h8000_000B);
    reg_wr(T_E0, 32'h1); reg_wr(T_E1, 32'h3); reg_wr(T_E2, 32'h3); reg_wr(T_E3, 32'h3);
    reg_wr(T_CTRL, 32'h7);
    bus(4'b1111);
    repeat (300) @(negedge clk);
    bus(4'b0000);
    reg_wr(T_CTRL, 32'h0);
    reg_rd(T_C0, v);  chk("R7 cnt0 wrapped", v, 32'(300 % 256));
    reg_rd(T_C1, v);  chk("R7 cnt1 wrapped", v, 32'(600 % 256));
    reg_rd(T_C2, v);  chk("R2 cnt2 disabled", v, 0);
    reg_rd(T_C3L, v); chk("R6 cnt3 low", v, 32'(600 % 256));
    reg_rd(T_C3H, v); chk("R6 cnt3 high", v, 32'(600 / 256));
    reg_rd(T_CYC, v); chk("R7 cycle wrapped", v, 32'(301 % 256));
    reg_rd(T_OVF, v); chk("R7 flags", v, 32'h8000_0003);
    reg_rd(T_E1, v);  chk("R4 evt1 readback", v, 3);
    reg_wr(T_OVF, 32'h1);
    reg_rd(T_OVF, v); chk("R7 w1c one bit", v, 32'h8000_0002);
    reg_wr(T_OVF, 32'h8000_0002);
    reg_rd(T_OVF, v); chk("R7 w1c rest", v, 0);

    // R2 enable set / clear
    reg_rd(T_CLR, v); chk("R2 clr reads state", v, 32'h8000_000B);
    reg_wr(T_CLR, 32'hFFFF_FFFF);
    reg_wr(T_SET, 32'hFFFF_FFF0);
    reg_rd(T_SET, v); chk("R2 ignored bits", v, 32'h8000_0000);
    reg_wr(T_SET, 32'h5);
    reg_rd(T_SET, v); chk("R2 set or", v, 32'h8000_0005);
    reg_wr(T_CLR, 32'h8000_0001);
    reg_rd(T_CLR, v); chk("R2 clear", v, 32'h4);

    // R9 unmapped reads
    reg_rd(8'h08, v); chk("R9 unmapped 08", v, 0);
    reg_rd(8'h58, v); chk("R9 unmapped 58", v, 0);
    reg_rd(8'h46, v); chk("R9 misaligned", v, 0);
    chk("R9 wr/rd ready", {30'd0, wr_ready, rd_ready}, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule